// File: doc/BRIEF.md
# Mirrored Filter Kernel Writer

This block fills a word-addressed context memory with a symmetric interpolation kernel. The caller supplies the sixteen 9-bit two's-complement coefficients of one half of a linear-phase kernel. It also supplies a 14-bit base address and a one-cycle start pulse. The block then packs three coefficients per 32-bit word and builds a six-word half-kernel. It emits eleven writes on consecutive cycles: the six half-kernel words in ascending order, then five of them again in descending order. Together these form the full symmetric kernel.

In the sixth half-kernel word the last coefficient sits in the two low slots and the top slot is zero. That word is the pivot of the mirror, so it is written only once. The coefficients and the base address are captured when a start is accepted. Changes on those inputs while a kernel is being written have no effect. A one-cycle done pulse marks the end of a burst.

The memory write port is a plain address/data/enable port with no back-pressure. The memory must accept a write on every cycle in which the enable is high. Start, base and done are plain control pins.

Top module: `kernel_mirror_writer`

## Requirements
- R1: While and right after reset, `mem_we_o` and `done_o` are low.
- R2: In every written word, slot 0 occupies bits 8:0, slot 1 bits 17:9 and slot 2 bits 26:18. Each slot holds a 9-bit coefficient copied bit for bit from its 9-bit field of `coef_i`.
- R3: Half-kernel word w (0 to 4) holds coefficients 3w, 3w+1 and 3w+2 in slots 0, 1 and 2. Half-kernel word 5 holds coefficient 15 in slots 0 and 1 and zero in slot 2.
- R4: Write i (0 to 10) carries half-kernel word i for i below 6, and half-kernel word 10−i for i from 6 to 10.
- R5: Write i goes to address base + i, taken modulo 2^14.
- R6: A start accepted at a clock edge is followed by exactly 11 cycles with `mem_we_o` high, beginning in the next cycle.
- R7: `done_o` is high for exactly the one cycle after the last write, and `mem_we_o` is low in that cycle.
- R8: A start that arrives while writes are in progress is ignored: the burst in progress continues unchanged and no extra burst follows.
- R9: Coefficients and base are sampled only when a start is accepted. Later changes to them do not alter the words or addresses of that burst.
- R10: Bits 31:27 of every written word are zero.
- R11: A start asserted in the cycle that `done_o` is high is accepted, and its first write follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| base_i | input | 14 | Memory address of kernel word 0 |
| coef_i | input | 144 | Sixteen 9-bit coefficients; coefficient k in bits 9k+8:9k |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 14 | Memory write address |
| mem_data_o | output | 32 | Memory write data |
| done_o | output | 1 | One-cycle pulse after the final write |

## Verification
The bench sweeps one coefficient at a time through all sixteen positions with its sign bit set, so every slot of every word is checked. A packer with a shifted or swapped slot would put that coefficient in the wrong word or field. The bench also writes the reference kernel, extreme values, several pseudo-random kernels, and a base near the top of the address range. A design that doubled the pivot word or mirrored from the wrong index would emit a wrong data sequence. One that carried the address sum past 14 bits would write outside the range. A start pulse and new coefficients are injected mid-burst to catch a design that restarts or re-reads its inputs. Back-to-back starts issued on the done cycle catch a design that loses the pulse or needs an idle gap.

// File: rtl/kmw_pkg.sv
package kmw_pkg;

  // Number of words in the half-kernel: the coefficient list with the last
  // coefficient repeated once, rounded up to whole words.
  function automatic int unsigned half_words(int unsigned ncoef, int unsigned per_word);
    return (ncoef + per_word) / per_word;
  endfunction

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } kmw_state_e;

endpackage

// File: rtl/kmw_pack.sv
module kmw_pack #(
  parameter int NCOEF = 16,
  parameter int CW    = 9,
  parameter int WPW   = 3,
  parameter int NHALF = 6,
  parameter int DW    = 32
) (
  input  logic [NCOEF*CW-1:0] coef_i,
  output logic [NHALF*DW-1:0] half_o
);

  localparam int USED = WPW * CW;

  for (genvar w = 0; w < NHALF; w++) begin : g_word
    for (genvar s = 0; s < WPW; s++) begin : g_slot
      localparam int P = w * WPW + s;
      if (P < NCOEF) begin : g_coef
        assign half_o[w*DW + s*CW +: CW] = coef_i[P*CW +: CW];
      end else if (P == NCOEF) begin : g_dup
        // the final coefficient appears a second time at the pivot
        assign half_o[w*DW + s*CW +: CW] = coef_i[(NCOEF-1)*CW +: CW];
      end else begin : g_zero
        assign half_o[w*DW + s*CW +: CW] = '0;
      end
    end
    if (DW > USED) begin : g_pad
      assign half_o[w*DW + USED +: DW-USED] = '0;
    end
  end

endmodule

// File: rtl/kmw_mirror.sv
module kmw_mirror #(
  parameter int NWORDS = 11,
  parameter int NHALF  = 6,
  parameter int IW     = 4,
  parameter int SW     = 3
) (
  input  logic [IW-1:0] idx_i,
  output logic [SW-1:0] sel_o
);

  localparam logic [IW-1:0] HALF_LIM = IW'(NHALF);
  localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

  logic [IW-1:0] rev_idx;

  always_comb begin
    rev_idx = LAST_IDX - idx_i;
    if (idx_i < HALF_LIM) sel_o = SW'(idx_i);
    else                  sel_o = SW'(rev_idx);
  end

endmodule

// File: rtl/kmw_seq.sv
module kmw_seq
  import kmw_pkg::*;
#(
  parameter int NWORDS = 11,
  parameter int IW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);

  localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS - 1);

  kmw_state_e state_q;

  assign busy_o   = (state_q == ST_RUN);
  assign accept_o = start_i && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            idx_o   <= '0;
          end
        end
        ST_RUN: begin
          if (idx_o == LAST_IDX) begin
            state_q <= ST_IDLE;
            idx_o   <= '0;
            done_o  <= 1'b1;
          end else begin
            idx_o <= idx_o + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/kernel_mirror_writer.sv
module kernel_mirror_writer
  import kmw_pkg::*;
#(
  parameter int NCOEF = 16,
  parameter int CW    = 9,
  parameter int WPW   = 3,
  parameter int AW    = 14,
  parameter int DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-1:0]       base_i,
  input  logic [NCOEF*CW-1:0] coef_i,
  output logic                mem_we_o,
  output logic [AW-1:0]       mem_addr_o,
  output logic [DW-1:0]       mem_data_o,
  output logic                done_o
);

  localparam int NHALF  = half_words(NCOEF, WPW);
  localparam int KWORDS = 2 * NHALF - 1;
  localparam int IW     = $clog2(KWORDS);
  localparam int SW     = $clog2(NHALF);

  logic                accept;
  logic                busy;
  logic [IW-1:0]       idx;
  logic [SW-1:0]       sel;
  logic [NCOEF*CW-1:0] coef_q;
  logic [AW-1:0]       base_q;
  logic [NHALF*DW-1:0] half_flat;
  logic [DW-1:0]       half_words_a [NHALF];

  // inputs are captured only when a start is accepted
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_q <= '0;
      base_q <= '0;
    end else if (accept) begin
      coef_q <= coef_i;
      base_q <= base_i;
    end
  end

  kmw_seq #(
    .NWORDS (KWORDS),
    .IW     (IW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .idx_o    (idx),
    .done_o   (done_o)
  );

  kmw_pack #(
    .NCOEF (NCOEF),
    .CW    (CW),
    .WPW   (WPW),
    .NHALF (NHALF),
    .DW    (DW)
  ) u_pack (
    .coef_i (coef_q),
    .half_o (half_flat)
  );

  kmw_mirror #(
    .NWORDS (KWORDS),
    .NHALF  (NHALF),
    .IW     (IW),
    .SW     (SW)
  ) u_mirror (
    .idx_i (idx),
    .sel_o (sel)
  );

  for (genvar w = 0; w < NHALF; w++) begin : g_unflat
    assign half_words_a[w] = half_flat[w*DW +: DW];
  end

  assign mem_we_o   = busy;
  assign mem_addr_o = base_q + AW'(idx);
  assign mem_data_o = half_words_a[sel];

endmodule

// File: rtl/kmw_checker.sv
module kmw_checker #(
  parameter int AW     = 14,
  parameter int DW     = 32,
  parameter int USED   = 27,
  parameter int NWORDS = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_data_o,
  input logic          done_o
);

  localparam int CNTW = $clog2(NWORDS + 1);

  logic [CNTW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        run_cnt <= '0;
    else if (mem_we_o) run_cnt <= run_cnt + 1'b1;
    else               run_cnt <= '0;
  end

  assert_pad_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_data_o[DW-1:USED] == '0));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_burst_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_o) |-> (run_cnt == CNTW'(NWORDS)));

  assert_burst_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (run_cnt < CNTW'(NWORDS)));

  assert_first_after_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> $past(start_i));

  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_o) |-> done_o);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_we_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

bind kernel_mirror_writer kmw_checker #(
  .AW     (AW),
  .DW     (DW),
  .USED   (WPW * CW),
  .NWORDS (KWORDS)
) u_kmw_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .done_o     (done_o)
);

// File: tb/test_kernel_mirror_writer.sv
`timescale 1ns/1ps
module test_kernel_mirror_writer;
  localparam int NC = 16;
  localparam int CW = 9;
  localparam int AW = 14;
  localparam int DW = 32;
  localparam int NW = 11;
  localparam int NH = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             start;
  logic [AW-1:0]    base;
  logic [NC*CW-1:0] coef;
  logic             we;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    data;
  logic             done;

  int errs   = 0;
  int checks = 0;
  logic [CW-1:0] exp_c [NC];
  logic [AW-1:0] exp_base;
  logic [31:0]   rng = 32'h1234_5677;
  int refv [NC] = '{0, -2, -6, -8, -10, -8, -3, 2, 18, 50, 82, 119, 155, 187, 213, 227};

  kernel_mirror_writer i_kernel_mirror_writer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .base_i     (base),
    .coef_i     (coef),
    .mem_we_o   (we),
    .mem_addr_o (addr),
    .mem_data_o (data),
    .done_o     (done)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_half(int w);
    logic [31:0] v = '0;
    for (int s = 0; s < 3; s++) begin
      int p = 3 * w + s;
      logic [CW-1:0] c;
      if (p < NC)       c = exp_c[p];
      else if (p == NC) c = exp_c[NC-1];
      else              c = '0;
      v[CW*s +: CW] = c;
    end
    return v;
  endfunction

  function automatic logic [31:0] next_rng(logic [31:0] x);
    logic [31:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic set_coef(int k, logic [CW-1:0] v);
    coef[k*CW +: CW] = v;
  endtask

  // called at a negedge; start is sampled at the following posedge
  task automatic launch(logic [AW-1:0] b);
    base  = b;
    start = 1'b1;
    exp_base = b;
    for (int k = 0; k < NC; k++) exp_c[k] = coef[k*CW +: CW];
    @(negedge clk);
    start = 1'b0;
  endtask

  // observes the 11 writes and the done cycle; returns at the done negedge
  task automatic observe(bit poke, string tag);
    for (int i = 0; i < NW; i++) begin
      int m = (i < NH) ? i : (NW - 1 - i);
      logic [AW-1:0] ea = exp_base + AW'(i);
      chk({tag, " R6 write enable"}, {31'd0, we}, 32'd1);
      chk({tag, " R5 address"}, {18'd0, addr}, {18'd0, ea});
      if (i < NH) chk({tag, " R3 forward word"}, data, exp_half(m));
      else        chk({tag, " R4 mirrored word"}, data, exp_half(m));
      if (i == NH - 1) chk({tag, " R10 pad bits"}, {27'd0, data[31:27]}, 32'd0);
      if (poke && i == 3) begin
        // R8 R9: mid-burst start with new base and coefficients
        start = 1'b1;
        base  = ~exp_base;
        for (int k = 0; k < NC; k++) set_coef(k, ~exp_c[k]);
      end
      if (poke && i == 4) start = 1'b0;
      @(negedge clk);
    end
    chk({tag, " R7 done pulse"}, {31'd0, done}, 32'd1);
    chk({tag, " R7 no write on done"}, {31'd0, we}, 32'd0);
  endtask

  task automatic idle_after(string tag);
    @(negedge clk);
    chk({tag, " R7 done one cycle"}, {31'd0, done}, 32'd0);
    chk({tag, " R8 no extra burst"}, {31'd0, we}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog R6: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    base  = '0;
    coef  = '0;
    repeat (3) @(negedge clk);
    chk("R1 write enable in reset", {31'd0, we}, 32'd0);
    chk("R1 done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 write enable after reset", {31'd0, we}, 32'd0);
    chk("R1 done after reset", {31'd0, done}, 32'd0);

    // reference kernel
    for (int k = 0; k < NC; k++) set_coef(k, CW'(refv[k]));
    launch(14'd100);
    observe(1'b0, "ref");
    idle_after("ref");

    // R2 sweep: one marked coefficient in each position in turn
    for (int k = 0; k < NC; k++) begin
      coef = '0;
      set_coef(k, 9'h100 | CW'(k + 1));
      launch(AW'(k * 37));
      observe(1'b0, "R2 sweep");
      idle_after("R2 sweep");
    end

    // extremes, base wrapping past the top of the address range
    for (int k = 0; k < NC; k++) set_coef(k, (k % 2) ? 9'h100 : 9'h0FF);
    launch(14'd16377);
    observe(1'b1, "wrap+poke R8 R9");
    idle_after("wrap+poke");

    // pseudo-random kernels; the middle ones chained back to back (R11)
    for (int r = 0; r < 6; r++) begin
      for (int k = 0; k < NC; k++) begin
        rng = next_rng(rng);
        set_coef(k, rng[CW-1:0]);
      end
      rng = next_rng(rng);
      if (r >= 2 && r <= 4) begin
        // started in the done cycle of the previous burst when chained
        if (r == 2) launch(rng[AW-1:0]);
        observe(1'b0, (r >= 3) ? "R11 chained" : "random");
        if (r < 4) begin
          for (int k = 0; k < NC; k++) begin
            rng = next_rng(rng);
            set_coef(k, rng[CW-1:0]);
          end
          launch(rng[AW+7:8]);
        end else begin
          idle_after("random");
        end
      end else begin
        launch(rng[AW-1:0]);
        observe(1'b0, "random");
        idle_after("random");
      end
    end

    repeat (5) @(negedge clk);
    chk("R8 idle stays quiet", {31'd0, we}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule